// File: doc/BRIEF.md
# Read Latency and Strobe Scheduler

This block watches SDRAM-style command pins on every rising clock edge. It picks out read commands and plans the output timing of each read. The delay from a read to its first data beat is the read latency. That latency is the sum of two separately programmed parts: a column-access latency and an extra posted delay. Each part is clamped to its legal range. The block samples both parts, together with the burst size, the ordering mode and the starting column, on the edge that carries the read. Later changes to these inputs do not affect a read that is already scheduled.

At the right moment the block turns on the strobe driver and holds the strobe low for one clock. This is the preamble. A data window follows, lasting one burst, in which the strobe follows the clock. Two beats move per clock. The rising-edge beat and the falling-edge beat each come with the column address they access, in the burst order selected for that read.

Pending reads wait in a shift pipeline. Reads spaced exactly one burst apart therefore run as one unbroken strobe, with no new preamble between them.

The beat stream is valid-only. A valid flag marks each clock that carries a beat pair. There is no ready input, because the memory timing cannot stall. A consumer must accept every flagged pair in the clock it appears.

Top module: `read_strobe_sched`

## Requirements
- R1: A read is taken on a rising edge when cs_n=0, ras_n=1, cas_n=0 and we_n=1. col_addr on that edge is the first column of the burst.
- R2: With cs_n=1 the edge is ignored, whatever the other pins are. Any other pin pattern with cs_n=0, for example a write (ras_n=1, cas_n=0, we_n=0), schedules nothing. In both cases no strobe or data appears.
- R3: Read latency RL equals clamp(cas_lat,2,7) plus min(add_lat,5). Both values are sampled on the command edge. For a command on edge E, the first beat pair is on the outputs in the cycle after edge E+RL.
- R4: In the cycle just before a burst's first pair, strobe_oe=1 and strobe_run=0 (the preamble). This holds unless data from an earlier read occupies that cycle.
- R5: The data window lasts 4 cycles when burst8=1 (8 beats) and 2 cycles when burst8=0 (4 beats). Throughout the window, data_valid=1, strobe_oe=1 and strobe_run=1.
- R6: In window cycle i, col_rise carries beat 2i and col_fall carries beat 2i+1. Burst order for beat n from start column s, when interleave=0: bits[1:0]=(s[1:0]+n[1:0]) mod 4, and bit 2 = s[2] xor n[2] for 8-beat bursts. Bits above the burst field are unchanged, and bit 2 is also unchanged for 4-beat bursts.
- R7: Reads with the same RL spaced exactly one burst duration apart give a continuous window, with no preamble and no gap between them.
- R8: Outside every preamble and data window, and after reset, strobe_oe, strobe_run and data_valid are 0 and both column outputs are 0.
- R9: With interleave=1 sampled on the command edge, the low burst bits are s xor n (bits [1:0] for 4-beat bursts, bits [2:0] for 8-beat bursts).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe command pin |
| cas_n | input | 1 | Column strobe command pin |
| we_n | input | 1 | Write enable command pin |
| col_addr | input | COL_W | Starting column, sampled with a read |
| cas_lat | input | LAT_W | Column-access latency setting |
| add_lat | input | LAT_W | Posted extra latency setting |
| burst8 | input | 1 | 1: 8-beat burst, 0: 4-beat burst |
| interleave | input | 1 | 1: interleaved order, 0: sequential order |
| data_valid | output | 1 | Beat pair present this cycle |
| strobe_oe | output | 1 | Strobe driver enable (0 = high impedance) |
| strobe_run | output | 1 | 1: strobe follows the clock, 0: strobe held low |
| col_rise | output | COL_W | Column of the rising-edge beat |
| col_fall | output | COL_W | Column of the falling-edge beat |

## Verification
A wrong slot in the pending pipeline shows up at the ports as a window that starts or ends one cycle off. It can also show as a missing or doubled preamble, or as a broken join between back-to-back bursts. Because every cycle of strobe_oe and strobe_run is compared, the error is seen in the first cycle it affects. A fault in the order logic gives a wrong col_rise or col_fall in the first affected beat pair. A fault in the latency sum or clamp moves the whole burst and is caught at the expected preamble cycle, RL-1 clocks after the command.

// File: rtl/rdsched_pkg.sv
package rdsched_pkg;

  typedef enum logic [1:0] {
    CMD_DESEL = 2'd0,
    CMD_READ  = 2'd1,
    CMD_OTHER = 2'd2
  } cmd_kind_e;

  // Low three column bits of beat number 'beat' in a burst starting at 'start'.
  function automatic logic [2:0] beat_low(input logic [2:0] start,
                                          input logic [2:0] beat,
                                          input logic       bl8,
                                          input logic       intlv);
    logic [2:0] r;
    if (intlv) r[1:0] = start[1:0] ^ beat[1:0];
    else       r[1:0] = start[1:0] + beat[1:0];
    r[2] = bl8 ? (start[2] ^ beat[2]) : start[2];
    return r;
  endfunction

endpackage

// File: rtl/cmd_decode.sv
module cmd_decode
  import rdsched_pkg::*;
(
  input  logic      cs_n,
  input  logic      ras_n,
  input  logic      cas_n,
  input  logic      we_n,
  output cmd_kind_e kind,
  output logic      rd_fire
);

  always_comb begin
    if (cs_n)                             kind = CMD_DESEL;
    else if ({ras_n, cas_n, we_n} == 3'b101) kind = CMD_READ;
    else                                  kind = CMD_OTHER;
    rd_fire = (kind == CMD_READ);
  end

endmodule

// File: rtl/latency_calc.sv
module latency_calc #(
  parameter int LAT_W  = 3,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 7,
  parameter int MAX_AL = 5,
  parameter int RL_W   = 4
) (
  input  logic [LAT_W-1:0] cas_lat,
  input  logic [LAT_W-1:0] add_lat,
  output logic [RL_W-1:0]  rl
);

  int cl_eff;
  int al_eff;

  always_comb begin
    if (int'(cas_lat) < MIN_CL)      cl_eff = MIN_CL;
    else if (int'(cas_lat) > MAX_CL) cl_eff = MAX_CL;
    else                             cl_eff = int'(cas_lat);
    al_eff = (int'(add_lat) > MAX_AL) ? MAX_AL : int'(add_lat);
    rl     = RL_W'(cl_eff + al_eff);
  end

endmodule

// File: rtl/burst_sched.sv
module burst_sched
  import rdsched_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int RL_W      = 4,
  parameter int MAX_PAIRS = 4,
  parameter int DEPTH     = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_fire,
  input  logic [RL_W-1:0]  rl,
  input  logic             bl8,
  input  logic             intlv,
  input  logic [COL_W-1:0] col,
  output logic             vld1,
  output logic             vld2,
  output logic [COL_W-1:0] rise1,
  output logic [COL_W-1:0] fall1
);

  // Slot j holds the beat pair that reaches the outputs j edges from now.
  logic [DEPTH:1]   slot_v;
  logic [COL_W-1:0] slot_r [1:DEPTH];
  logic [COL_W-1:0] slot_f [1:DEPTH];

  for (genvar j = 1; j <= DEPTH; j++) begin : g_slot
    logic             up_v;
    logic [COL_W-1:0] up_r;
    logic [COL_W-1:0] up_f;
    int               off;
    logic             hit;
    logic [1:0]       pair;

    if (j < DEPTH) begin : g_mid
      assign up_v = slot_v[j+1];
      assign up_r = slot_r[j+1];
      assign up_f = slot_f[j+1];
    end else begin : g_end
      assign up_v = 1'b0;
      assign up_r = '0;
      assign up_f = '0;
    end

    always_comb begin
      off  = j - int'(rl);
      hit  = rd_fire && (off >= 0) && (off < (bl8 ? MAX_PAIRS : MAX_PAIRS / 2));
      pair = off[1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slot_v[j] <= 1'b0;
        slot_r[j] <= '0;
        slot_f[j] <= '0;
      end else if (hit) begin
        slot_v[j] <= 1'b1;
        slot_r[j] <= {col[COL_W-1:3], beat_low(col[2:0], {pair, 1'b0}, bl8, intlv)};
        slot_f[j] <= {col[COL_W-1:3], beat_low(col[2:0], {pair, 1'b1}, bl8, intlv)};
      end else begin
        slot_v[j] <= up_v;
        slot_r[j] <= up_r;
        slot_f[j] <= up_f;
      end
    end
  end

  assign vld1  = slot_v[1];
  assign vld2  = slot_v[2];
  assign rise1 = slot_r[1];
  assign fall1 = slot_f[1];

endmodule

// File: rtl/strobe_out.sv
module strobe_out #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld1,
  input  logic             vld2,
  input  logic [COL_W-1:0] rise1,
  input  logic [COL_W-1:0] fall1,
  output logic             data_valid,
  output logic             strobe_oe,
  output logic             strobe_run,
  output logic [COL_W-1:0] col_rise,
  output logic [COL_W-1:0] col_fall
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_valid <= 1'b0;
      strobe_oe  <= 1'b0;
      strobe_run <= 1'b0;
      col_rise   <= '0;
      col_fall   <= '0;
    end else begin
      data_valid <= vld1;
      strobe_run <= vld1;
      strobe_oe  <= vld1 | vld2;
      col_rise   <= vld1 ? rise1 : '0;
      col_fall   <= vld1 ? fall1 : '0;
    end
  end

endmodule

// File: rtl/read_strobe_sched.sv
module read_strobe_sched
  import rdsched_pkg::*;
#(
  parameter int COL_W  = 10,
  parameter int LAT_W  = 3,
  parameter int MIN_CL = 2,
  parameter int MAX_CL = 7,
  parameter int MAX_AL = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [COL_W-1:0] col_addr,
  input  logic [LAT_W-1:0] cas_lat,
  input  logic [LAT_W-1:0] add_lat,
  input  logic             burst8,
  input  logic             interleave,
  output logic             data_valid,
  output logic             strobe_oe,
  output logic             strobe_run,
  output logic [COL_W-1:0] col_rise,
  output logic [COL_W-1:0] col_fall
);

  localparam int MAX_PAIRS = 4;
  localparam int MAX_RL    = MAX_CL + MAX_AL;
  localparam int RL_W      = $clog2(MAX_RL + 1);
  localparam int DEPTH     = MAX_RL + MAX_PAIRS - 1;

  cmd_kind_e        kind;
  logic             rd_fire;
  logic [RL_W-1:0]  rl;
  logic             vld1, vld2;
  logic [COL_W-1:0] rise1, fall1;

  cmd_decode u_dec (
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .kind(kind), .rd_fire(rd_fire)
  );

  latency_calc #(
    .LAT_W(LAT_W), .MIN_CL(MIN_CL), .MAX_CL(MAX_CL), .MAX_AL(MAX_AL), .RL_W(RL_W)
  ) u_lat (
    .cas_lat(cas_lat), .add_lat(add_lat), .rl(rl)
  );

  burst_sched #(
    .COL_W(COL_W), .RL_W(RL_W), .MAX_PAIRS(MAX_PAIRS), .DEPTH(DEPTH)
  ) u_sched (
    .clk(clk), .rst_n(rst_n), .rd_fire(rd_fire), .rl(rl),
    .bl8(burst8), .intlv(interleave), .col(col_addr),
    .vld1(vld1), .vld2(vld2), .rise1(rise1), .fall1(fall1)
  );

  strobe_out #(.COL_W(COL_W)) u_out (
    .clk(clk), .rst_n(rst_n), .vld1(vld1), .vld2(vld2),
    .rise1(rise1), .fall1(fall1),
    .data_valid(data_valid), .strobe_oe(strobe_oe), .strobe_run(strobe_run),
    .col_rise(col_rise), .col_fall(col_fall)
  );

endmodule

// File: rtl/read_strobe_sched_chk.sv
module read_strobe_sched_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             data_valid,
  input logic             strobe_oe,
  input logic             strobe_run,
  input logic [COL_W-1:0] col_rise,
  input logic [COL_W-1:0] col_fall
);

  assert_run_needs_oe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_run |-> strobe_oe);

  assert_valid_with_run_R5: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid == strobe_run);

  assert_preamble_then_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_oe && !strobe_run) |=> strobe_run);

  assert_pair_bit0_differs_R6: assert property (@(posedge clk) disable iff (!rst_n)
    data_valid |-> (col_rise[0] != col_fall[0]));

  assert_idle_cols_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !data_valid |-> (col_rise == '0 && col_fall == '0));

endmodule

bind read_strobe_sched read_strobe_sched_chk #(.COL_W(COL_W)) chk_i (.*);

// File: tb/read_strobe_sched_tb_top.sv
module read_strobe_sched_tb_top;

  localparam int COL_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [COL_W-1:0] col_addr = '0;
  logic [2:0] cas_lat = 3'd3, add_lat = 3'd0;
  logic burst8 = 1'b0, interleave = 1'b0;
  logic data_valid, strobe_oe, strobe_run;
  logic [COL_W-1:0] col_rise, col_fall;

  always #2 clk = ~clk;

  read_strobe_sched dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col_addr(col_addr), .cas_lat(cas_lat), .add_lat(add_lat),
    .burst8(burst8), .interleave(interleave),
    .data_valid(data_valid), .strobe_oe(strobe_oe), .strobe_run(strobe_run),
    .col_rise(col_rise), .col_fall(col_fall)
  );

  typedef struct {
    int               cyc;
    logic [COL_W-1:0] r;
    logic [COL_W-1:0] f;
    string            req;
  } item_t;

  item_t exp_q[$];
  bit    exp_oe  [8192];
  bit    exp_run [8192];
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  bit    seen_dv = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [COL_W-1:0] ref_col(logic [COL_W-1:0] s, int n, bit bl8, bit il);
    int lo;
    int nib;
    if (il) lo = bl8 ? ((s[2:0] ^ n[2:0]) & 7) : (s[2] * 4 + ((s[1:0] ^ n[1:0]) & 3));
    else begin
      nib = bl8 ? (s[2] ^ n[2]) : s[2];
      lo  = nib * 4 + ((s[1:0] + n) % 4);
    end
    return {s[COL_W-1:3], 3'(lo)};
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(logic [COL_W-1:0] col, int cl, int al, bit bl8, bit il, string req);
    int e, rl, pairs, cle, ale;
    @(negedge clk);
    cs_n = 0; ras_n = 1; cas_n = 0; we_n = 1;
    col_addr = col; cas_lat = 3'(cl); add_lat = 3'(al); burst8 = bl8; interleave = il;
    e   = cyc + 1;
    cle = (cl < 2) ? 2 : ((cl > 7) ? 7 : cl);
    ale = (al > 5) ? 5 : al;
    rl  = cle + ale;
    pairs = bl8 ? 4 : 2;
    for (int i = 0; i < pairs; i++) begin
      item_t it;
      it.cyc = e + rl + i;
      it.r   = ref_col(col, 2 * i, bl8, il);
      it.f   = ref_col(col, 2 * i + 1, bl8, il);
      it.req = req;
      exp_q.push_back(it);
      exp_oe[e + rl + i]  = 1;
      exp_run[e + rl + i] = 1;
    end
    if (!exp_run[e + rl - 1]) exp_oe[e + rl - 1] = 1;
    @(negedge clk);
    cs_n = 1; col_addr = ~col; cas_lat = ~cas_lat; add_lat = ~add_lat;
    burst8 = ~bl8; interleave = ~il;
  endtask

  task automatic raw_cmd(logic c, logic r, logic a, logic w);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = a; we_n = w;
    col_addr = 10'h155; cas_lat = 3'd2; add_lat = 3'd0; burst8 = 0;
    @(negedge clk);
    cs_n = 1; ras_n = 1; cas_n = 1; we_n = 1;
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      int c;
      int idx;
      string tag;
      c = cyc;
      if (data_valid) seen_dv = 1;
      tag = exp_run[c] ? "R5" : (exp_oe[c] ? "R4" : "R8");
      checks++;
      if (strobe_oe !== exp_oe[c] || strobe_run !== exp_run[c]) begin
        errors++;
        $display("FAIL %s cyc %0d strobe oe/run actual %b%b expected %b%b",
                 tag, c, strobe_oe, strobe_run, exp_oe[c], exp_run[c]);
      end
      idx = -1;
      foreach (exp_q[k]) if (exp_q[k].cyc == c) idx = k;
      if (idx >= 0) begin
        checks++;
        if (data_valid !== 1'b1 || col_rise !== exp_q[idx].r || col_fall !== exp_q[idx].f) begin
          errors++;
          $display("FAIL %s cyc %0d beat pair actual v=%b %h/%h expected v=1 %h/%h",
                   exp_q[idx].req, c, data_valid, col_rise, col_fall, exp_q[idx].r, exp_q[idx].f);
        end
        exp_q.delete(idx);
      end else if (data_valid) begin
        checks++;
        errors++;
        $display("FAIL R2 cyc %0d unexpected data actual v=1 expected v=0", c);
      end
    end
  end

  initial begin
    #(4 * 100000);
    errors++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    @(negedge clk);
    checks++;
    if (data_valid || strobe_oe || strobe_run || col_rise != 0 || col_fall != 0) begin
      errors++;
      $display("FAIL R8 reset state actual %b%b%b %h %h expected 000 000 000",
               data_valid, strobe_oe, strobe_run, col_rise, col_fall);
    end

    issue(10'h001, 3, 0, 0, 0, "R1 R3 R6");   idle(16);
    issue(10'h2D5, 4, 1, 1, 0, "R5 R6");      idle(16);
    issue(10'h0E3, 5, 2, 1, 1, "R9 R6");      idle(16);
    issue(10'h3FA, 2, 0, 0, 1, "R9");         idle(16);
    issue(10'h10F, 1, 7, 0, 0, "R3 clamp");   idle(16);
    issue(10'h0A6, 0, 0, 1, 0, "R3 min");     idle(16);

    // back-to-back 4-beat bursts, two cycles apart
    issue(10'h004, 3, 1, 0, 0, "R7");
    issue(10'h009, 3, 1, 0, 1, "R7");
    issue(10'h00E, 3, 1, 0, 0, "R7");
    idle(16);
    // back-to-back 8-beat bursts, four cycles apart
    issue(10'h1F1, 4, 0, 1, 0, "R7");
    idle(2);
    issue(10'h1F6, 4, 0, 1, 1, "R7");
    idle(16);

    // differing latencies: later read lands first
    issue(10'h222, 7, 5, 0, 0, "R3 long");
    issue(10'h333, 2, 0, 0, 0, "R3 short");
    idle(20);

    // ignored commands
    seen_dv = 0;
    raw_cmd(1, 1, 0, 1);   // deselected read pattern
    raw_cmd(0, 1, 0, 0);   // write
    raw_cmd(0, 0, 1, 1);   // row activate
    idle(20);
    checks++;
    if (seen_dv) begin
      errors++;
      $display("FAIL R2 ignored commands actual data=1 expected data=0");
    end

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 beat pairs never delivered actual %0d left expected 0", exp_q.size());
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule